// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the hardwired sequencer for a 32-bit load/store processor that runs each instruction over several clock cycles. The processor shares one memory between instruction and data accesses and has one ALU. Each cycle the block reads the 6-bit operation code held in the instruction register. It steps through a fixed set of ten states and drives the select, enable and write-strobe lines of the datapath for each one. The register file, ALU, memory and the multiplexers they feed sit outside it.

All instructions begin with two shared steps. FETCH reads the instruction and advances the program counter by four. DECODE latches both source registers and, in the same cycle, computes the branch target speculatively with the ALU. After DECODE the sequence splits by instruction class. Loads run ADDR, LD_MEM, LD_WB. Stores run ADDR, ST_MEM. Register-register operations run EXEC, R_WB. A branch-if-equal runs BRANCH and a jump runs JUMP. Every path ends with a return to FETCH. The outputs are Moore outputs: they depend only on the current state. The state number is brought out on `step_id` so the surrounding logic and the bench can follow the sequence.

Named transitions: FETCH→DECODE; DECODE→ADDR (load or store), DECODE→EXEC (register op), DECODE→BRANCH, DECODE→JUMP, DECODE→FETCH (unrecognised code); ADDR→LD_MEM (load), ADDR→ST_MEM (store); LD_MEM→LD_WB; EXEC→R_WB; LD_WB, ST_MEM, R_WB, BRANCH and JUMP →FETCH.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` places the controller in FETCH (`step_id`=0) at the next clock edge, whatever state it was in.
- R2: FETCH (`step_id`=0) drives `mem_rd`=1, `ir_we`=1, `pc_we`=1, `alu_b_sel`=2'b01, `pc_src`=2'b00, `alu_op`=2'b00, `alu_a_sel`=0, `addr_sel_alu`=0, and always moves to DECODE (`step_id`=1).
- R3: DECODE drives `alu_b_sel`=2'b11 with `alu_op`=2'b00 and `alu_a_sel`=0. It then dispatches on `opcode`: 6'h23 (load) and 6'h2B (store) go to ADDR (2), 6'h00 (register op) to EXEC (6), 6'h04 (branch) to BRANCH (8), and 6'h02 (jump) to JUMP (9).
- R4: Any other `opcode` seen in DECODE sends the controller back to FETCH, and no state after DECODE is entered.
- R5: ADDR (2) drives `alu_a_sel`=1, `alu_b_sel`=2'b10, `alu_op`=2'b00. It goes to LD_MEM (3) for 6'h23 and to ST_MEM (5) otherwise.
- R6: LD_MEM (3) drives `mem_rd`=1 and `addr_sel_alu`=1, then goes to LD_WB (4). LD_WB drives `rf_we`=1, `rf_wdata_mdr`=1 and `dst_sel_rd`=0.
- R7: ST_MEM (5) drives `mem_wr`=1 and `addr_sel_alu`=1.
- R8: EXEC (6) drives `alu_a_sel`=1, `alu_b_sel`=2'b00, `alu_op`=2'b10, then goes to R_WB (7). R_WB drives `dst_sel_rd`=1, `rf_we`=1 and `rf_wdata_mdr`=0.
- R9: BRANCH (8) drives `alu_a_sel`=1, `alu_b_sel`=2'b00, `alu_op`=2'b01, `pc_we_cond`=1 and `pc_src`=2'b01.
- R10: JUMP (9) drives `pc_we`=1 and `pc_src`=2'b10.
- R11: LD_WB, ST_MEM, R_WB, BRANCH and JUMP each return to FETCH on the next clock edge.
- R12: Every control line that is not listed for a state is 0. Consequently `mem_rd` and `mem_wr` are never both 1, and neither are `pc_we` and `pc_we_cond`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Operation code from the instruction register |
| dst_sel_rd | output | 1 | 1: write destination from the rd field; 0: from rt |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | 1: ALU operand A is register A; 0: the PC |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| rf_wdata_mdr | output | 1 | 1: register write data from the memory data register; 0: from the ALU result register |
| addr_sel_alu | output | 1 | 1: memory address from the ALU result register; 0: from the PC |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write qualified by the ALU zero flag |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field decides |
| alu_b_sel | output | 2 | 00 register B, 01 constant 4, 10 sign-extended immediate, 11 sign-extended immediate shifted left 2 |
| pc_src | output | 2 | 00 ALU output, 01 ALU result register, 10 jump target |
| step_id | output | 4 | Current state number (0 to 9) |

## Verification
The bench runs a load, a store, a register op, a branch and a jump back to back, so each dispatch arm out of DECODE and both arms out of ADDR are taken. The load and store pair shows whether ADDR splits on the opcode rather than always going one way. Two unrecognised codes, 6'h3F and 6'h08, show whether DECODE falls back to FETCH and does not fall into some execute state. A reset raised in the middle of a register op shows that the controller returns from a deep state, and a second sweep with the classes in a different order shows that no state is carried over from one instruction to the next.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int STEP_W = 4;

    // State numbering matches the published step_id values.
    typedef enum logic [STEP_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LD_MEM = 4'd3,
        ST_LD_WB  = 4'd4,
        ST_ST_MEM = 4'd5,
        ST_EXEC   = 4'd6,
        ST_R_WB   = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } step_t;

    localparam logic [1:0] ALU_ADD   = 2'b00;
    localparam logic [1:0] ALU_SUB   = 2'b01;
    localparam logic [1:0] ALU_FUNCT = 2'b10;

    localparam logic [1:0] BSEL_REG    = 2'b00;
    localparam logic [1:0] BSEL_FOUR   = 2'b01;
    localparam logic [1:0] BSEL_IMM    = 2'b10;
    localparam logic [1:0] BSEL_IMM_X4 = 2'b11;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_REG  = 2'b01;
    localparam logic [1:0] PCS_JUMP = 2'b10;

    typedef struct packed {
        logic       dst_sel_rd;
        logic       rf_we;
        logic       alu_a_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       rf_wdata_mdr;
        logic       addr_sel_alu;
        logic       ir_we;
        logic       pc_we;
        logic       pc_we_cond;
        logic [1:0] alu_op;
        logic [1:0] alu_b_sel;
        logic [1:0] pc_src;
    } ctrl_t;

endpackage

// File: rtl/mc_step_next.sv
module mc_step_next
    import mc_ctrl_pkg::*;
#(
    parameter int                OPC_W   = 6,
    parameter logic [OPC_W-1:0]  OP_RTYP = 6'h00,
    parameter logic [OPC_W-1:0]  OP_LOAD = 6'h23,
    parameter logic [OPC_W-1:0]  OP_STOR = 6'h2B,
    parameter logic [OPC_W-1:0]  OP_BREQ = 6'h04,
    parameter logic [OPC_W-1:0]  OP_JUMP = 6'h02
) (
    input  step_t             cur,
    input  logic [OPC_W-1:0]  opcode,
    output step_t             nxt
);

    step_t dispatch;

    // Decode-time dispatch on the instruction class.
    always_comb begin
        if (opcode == OP_LOAD || opcode == OP_STOR) dispatch = ST_ADDR;
        else if (opcode == OP_RTYP)                 dispatch = ST_EXEC;
        else if (opcode == OP_BREQ)                 dispatch = ST_BRANCH;
        else if (opcode == OP_JUMP)                 dispatch = ST_JUMP;
        else                                        dispatch = ST_FETCH;
    end

    always_comb begin
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = dispatch;
            ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_LD_MEM : ST_ST_MEM;
            ST_LD_MEM: nxt = ST_LD_WB;
            ST_EXEC:   nxt = ST_R_WB;
            ST_LD_WB,
            ST_ST_MEM,
            ST_R_WB,
            ST_BRANCH,
            ST_JUMP:   nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_step_ctrl.sv
module mc_step_ctrl
    import mc_ctrl_pkg::*;
(
    input  step_t cur,
    output ctrl_t ctl
);

    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_we     = 1'b1;
                ctl.pc_we     = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_op    = ALU_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSEL_IMM_X4;
                ctl.alu_op    = ALU_ADD;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_op    = ALU_ADD;
            end
            ST_LD_MEM: begin
                ctl.mem_rd       = 1'b1;
                ctl.addr_sel_alu = 1'b1;
            end
            ST_LD_WB: begin
                ctl.rf_we        = 1'b1;
                ctl.rf_wdata_mdr = 1'b1;
            end
            ST_ST_MEM: begin
                ctl.mem_wr       = 1'b1;
                ctl.addr_sel_alu = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_op    = ALU_FUNCT;
            end
            ST_R_WB: begin
                ctl.dst_sel_rd = 1'b1;
                ctl.rf_we      = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = BSEL_REG;
                ctl.alu_op     = ALU_SUB;
                ctl.pc_we_cond = 1'b1;
                ctl.pc_src     = PCS_REG;
            end
            ST_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_JUMP;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int                OPC_W   = 6,
    parameter logic [OPC_W-1:0]  OP_RTYP = 6'h00,
    parameter logic [OPC_W-1:0]  OP_LOAD = 6'h23,
    parameter logic [OPC_W-1:0]  OP_STOR = 6'h2B,
    parameter logic [OPC_W-1:0]  OP_BREQ = 6'h04,
    parameter logic [OPC_W-1:0]  OP_JUMP = 6'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    output logic              dst_sel_rd,
    output logic              rf_we,
    output logic              alu_a_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              rf_wdata_mdr,
    output logic              addr_sel_alu,
    output logic              ir_we,
    output logic              pc_we,
    output logic              pc_we_cond,
    output logic [1:0]        alu_op,
    output logic [1:0]        alu_b_sel,
    output logic [1:0]        pc_src,
    output logic [STEP_W-1:0] step_id
);

    step_t state_q;
    step_t state_d;
    ctrl_t ctl;

    mc_step_next #(
        .OPC_W  (OPC_W),
        .OP_RTYP(OP_RTYP),
        .OP_LOAD(OP_LOAD),
        .OP_STOR(OP_STOR),
        .OP_BREQ(OP_BREQ),
        .OP_JUMP(OP_JUMP)
    ) u_next (
        .cur   (state_q),
        .opcode(opcode),
        .nxt   (state_d)
    );

    mc_step_ctrl u_ctrl (
        .cur(state_q),
        .ctl(ctl)
    );

    // State register, synchronous reset.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    // Output unpacking.
    always_comb begin
        dst_sel_rd   = ctl.dst_sel_rd;
        rf_we        = ctl.rf_we;
        alu_a_sel    = ctl.alu_a_sel;
        mem_rd       = ctl.mem_rd;
        mem_wr       = ctl.mem_wr;
        rf_wdata_mdr = ctl.rf_wdata_mdr;
        addr_sel_alu = ctl.addr_sel_alu;
        ir_we        = ctl.ir_we;
        pc_we        = ctl.pc_we;
        pc_we_cond   = ctl.pc_we_cond;
        alu_op       = ctl.alu_op;
        alu_b_sel    = ctl.alu_b_sel;
        pc_src       = ctl.pc_src;
        step_id      = state_q;
    end

    logic opc_known;
    assign opc_known = (opcode == OP_RTYP) || (opcode == OP_LOAD) || (opcode == OP_STOR)
                    || (opcode == OP_BREQ) || (opcode == OP_JUMP);

    AST_RESET_TO_FETCH: assert property (@(posedge clk) rst |=> step_id == 4'd0); // R1
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        step_id == 4'd0 |=> step_id == 4'd1); // R2
    AST_UNKNOWN_OPC_REFETCH: assert property (@(posedge clk) disable iff (rst)
        (step_id == 4'd1 && !opc_known) |=> step_id == 4'd0); // R4
    AST_LOAD_MEM_TO_WB: assert property (@(posedge clk) disable iff (rst)
        step_id == 4'd3 |=> step_id == 4'd4); // R6
    AST_EXEC_TO_RWB: assert property (@(posedge clk) disable iff (rst)
        step_id == 4'd6 |=> step_id == 4'd7); // R8
    AST_TAIL_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (step_id == 4'd4 || step_id == 4'd5 || step_id == 4'd7 || step_id == 4'd8 || step_id == 4'd9)
        |=> step_id == 4'd0); // R11
    AST_MEM_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R12
    AST_PC_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pc_we && pc_we_cond)); // R12

endmodule

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic dst_sel_rd, rf_we, alu_a_sel, mem_rd, mem_wr, rf_wdata_mdr;
    logic addr_sel_alu, ir_we, pc_we, pc_we_cond;
    logic [1:0] alu_op, alu_b_sel, pc_src;
    logic [3:0] step_id;

    int n_vec  = 0;
    int n_bad  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .dst_sel_rd(dst_sel_rd), .rf_we(rf_we), .alu_a_sel(alu_a_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_wdata_mdr(rf_wdata_mdr),
        .addr_sel_alu(addr_sel_alu), .ir_we(ir_we), .pc_we(pc_we),
        .pc_we_cond(pc_we_cond), .alu_op(alu_op), .alu_b_sel(alu_b_sel),
        .pc_src(pc_src), .step_id(step_id)
    );

    // Behavioural reference model.
    int   m_st   = 0;
    int   m_prev = 0;
    bit   m_rst  = 1'b0;
    bit   m_unk  = 1'b0;
    bit   armed  = 1'b0;

    function automatic int ref_next(int s, logic [5:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'h23 || op == 6'h2B) return 2;
                if (op == 6'h00) return 6;
                if (op == 6'h04) return 8;
                if (op == 6'h02) return 9;
                return 0;
            end
            2: return (op == 6'h23) ? 3 : 5;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    // {dst_rd, rf_we, a_sel, mem_rd, mem_wr, wb_mdr, addr_alu, ir_we, pc_we, pc_we_cond, alu_op, b_sel, pc_src}
    function automatic logic [15:0] ref_ctrl(int s);
        case (s)
            0: return 16'b0001000110_00_01_00;
            1: return 16'b0000000000_00_11_00;
            2: return 16'b0010000000_00_10_00;
            3: return 16'b0001001000_00_00_00;
            4: return 16'b0100010000_00_00_00;
            5: return 16'b0000101000_00_00_00;
            6: return 16'b0010000000_10_00_00;
            7: return 16'b1100000000_00_00_00;
            8: return 16'b0010000001_01_00_01;
            9: return 16'b0000000010_00_00_10;
            default: return 16'hxxxx;
        endcase
    endfunction

    function automatic string ctrl_tag(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic string step_tag(int p, bit r, bit u);
        if (r) return "R1";
        if (u) return "R4";
        case (p)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            6: return "R8";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        armed  <= 1'b1;
        m_prev <= m_st;
        m_rst  <= rst;
        m_unk  <= (m_st == 1) && (ref_next(1, opcode) == 0);
        m_st   <= rst ? 0 : ref_next(m_st, opcode);
    end

    always @(negedge clk) begin
        if (armed) begin
            logic [15:0] got;
            logic [15:0] exp;
            got = {dst_sel_rd, rf_we, alu_a_sel, mem_rd, mem_wr, rf_wdata_mdr,
                   addr_sel_alu, ir_we, pc_we, pc_we_cond, alu_op, alu_b_sel, pc_src};
            exp = ref_ctrl(m_st);
            n_vec++;
            if (step_id !== 4'(m_st)) begin
                n_bad++;
                $display("FAIL %s step_id got %0d expected %0d", step_tag(m_prev, m_rst, m_unk), step_id, m_st);
            end
            n_vec++;
            if (got !== exp) begin
                n_bad++;
                $display("FAIL %s controls in step %0d got %b expected %b", ctrl_tag(m_st), m_st, got, exp);
            end
            n_vec++;
            if ((mem_rd && mem_wr) || (pc_we && pc_we_cond)) begin
                n_bad++;
                $display("FAIL R12 exclusive strobes got rd/wr/pc/pcc %b%b%b%b expected none paired",
                         mem_rd, mem_wr, pc_we, pc_we_cond);
            end
        end
    end

    task automatic run_op(input logic [5:0] op);
        opcode = op;
        do @(negedge clk); while (m_st != 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // First sweep: every class, then two unknown codes (R4).
        run_op(6'h23);
        run_op(6'h2B);
        run_op(6'h00);
        run_op(6'h04);
        run_op(6'h02);
        run_op(6'h3F);
        run_op(6'h08);
        // Reset raised in the middle of a register op (R1).
        opcode = 6'h00;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // Second sweep in a different order.
        run_op(6'h02);
        run_op(6'h2B);
        run_op(6'h04);
        run_op(6'h23);
        run_op(6'h00);
        run_op(6'h23);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        n_bad++;
        $display("FAIL watchdog expired got %0d cycles expected under 5000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule